// File: doc/BRIEF.md
# Match-Compare System Timer

This block is a system timer. It has a single free-running 32-bit up-counter and four 32-bit compare channels. The counter advances once on every clock cycle in which the external `tick` strobe is high, so any prescaling is done outside the block. When a tick moves the counter onto a value that equals a channel's compare register, that channel is said to hit. A hit latches the channel's status bit and raises its interrupt line, but only if the channel's enable bit is set. Software acknowledges an interrupt by writing a one to the status bit. A written zero leaves a bit as it is.

Channel 3 can also act as a watchdog. It has a one-bit arm register. When channel 3 hits while the arm bit is set, the block emits a single-cycle reset request and disarms itself. This happens whether or not interrupts are enabled for channel 3.

Software reaches every register through a simple 32-bit bus. A write is a single-cycle strobe with an address and data. Read data is combinational from the address. All offsets are byte addresses and are decoded exactly.

Top module: `ostmr_top`

## Requirements
- R1: After reset, the counter, all four compare registers, the status register, the interrupt-enable register and the watchdog arm bit read as zero. `irq` and `resetReq` are low.
- R2: The counter (offset 0x10) increases by one, wrapping from 0xFFFFFFFF to 0, on each clock edge where `tick` is high. Without a tick or a counter write it holds its value.
- R3: A write to offset 0x10 loads the written value. If a tick occurs in the same cycle, the write wins. Later ticks count on from the loaded value.
- R4: When a tick moves the counter onto the value of compare register n, and interrupt-enable bit n is set, then status bit n and `irq[n]` go high. This happens on the same clock edge that updates the counter. `irq[n]` stays high until it is cleared.
- R5: A hit on a channel whose enable bit is clear changes neither its status bit nor its interrupt line.
- R6: Loading the counter through a bus write never counts as a hit, even when the loaded value equals a compare register.
- R7: A write to the status register (offset 0x14, bit n = channel n) clears every bit written as 1 and drops the matching `irq` lines. Bits written as 0 are untouched. A hit in the same cycle as the clear sets its bit anyway.
- R8: The interrupt-enable register (offset 0x1C, bit n enables channel n) stores only bits 11:0 of a write. Bits 31:12 always read as zero.
- R9: If the watchdog arm bit (offset 0x18, bit 0, the only bit stored) is set when channel 3 hits, `resetReq` goes high on that edge and the arm bit reads 0 afterwards. This does not depend on enable bit 3. A bus write to offset 0x18 in the same cycle takes precedence for the arm bit.
- R10: `resetReq` is high for exactly one cycle per watchdog hit and is low otherwise.
- R11: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C return zero, and writes to them change nothing.
- R12: Compare register n is written and read at offset 4·n (0x00, 0x04, 0x08, 0x0C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable strobe, one count per high cycle |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational from `busAddr` |
| irq | output | 4 | Per-channel interrupt levels (same as the status bits) |
| resetReq | output | 1 | One-cycle watchdog reset request |

## Verification
Compare hits are tried in several ways: with the channel enabled, with it disabled, with the counter loaded straight onto a compare value, and with a hit in the same cycle as a status clear. Together these separate a tick-driven hit from a mere equality, and show which of set and clear wins. The counter is driven through a wrap from 0xFFFFFFFE, and through a load in the same cycle as a tick, to expose an off-by-one or a wrong priority. The watchdog is fired armed, then re-run disarmed, with its interrupt enable off. This shows that the reset request comes from the arm bit alone, that it lasts one cycle, and that the bit clears itself.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int CH_NUM = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IER_W = 12;
  localparam int WD_CH = 3;
  localparam int IDX_W = $clog2(CH_NUM);
  localparam int MATCH_STRIDE = 4;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_WDOG   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IER    = 8'h1C;

  typedef struct packed {
    logic [CH_NUM-1:0] wrMatch;
    logic              wrCount;
    logic              wrStatus;
    logic              wrWdog;
    logic              wrIer;
  } busStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MATCH,
    RD_COUNT,
    RD_STATUS,
    RD_WDOG,
    RD_IER
  } rdSel_t;
endpackage

// File: rtl/ostmr_ctrl.sv
module ostmr_ctrl
  import ostmr_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        strobe,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  rdIdx
);
  logic [CH_NUM-1:0] matchHit;

  for (genvar i = 0; i < CH_NUM; i++) begin : g_dec
    assign matchHit[i] = (addr == ADDR_W'(i * MATCH_STRIDE));
  end

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    rdIdx  = '0;
    strobe.wrMatch = wrEn ? matchHit : '0;
    for (int i = 0; i < CH_NUM; i++) begin
      if (matchHit[i]) begin
        rdSel = RD_MATCH;
        rdIdx = IDX_W'(i);
      end
    end
    case (addr)
      OFS_COUNT:  begin rdSel = RD_COUNT;  strobe.wrCount  = wrEn; end
      OFS_STATUS: begin rdSel = RD_STATUS; strobe.wrStatus = wrEn; end
      OFS_WDOG:   begin rdSel = RD_WDOG;   strobe.wrWdog   = wrEn; end
      OFS_IER:    begin rdSel = RD_IER;    strobe.wrIer    = wrEn; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ostmr_dpath.sv
module ostmr_dpath
  import ostmr_pkg::*;
#(
  parameter int IER_BITS = IER_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  busStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             countQ,
  output logic [CH_NUM-1:0][DATA_W-1:0] matchQ,
  output logic [CH_NUM-1:0]             statusQ,
  output logic [IER_BITS-1:0]           ierQ,
  output logic                          wdEnQ,
  output logic                          resetReq
);
  logic [DATA_W-1:0] countNext;
  logic              stepping;
  logic [CH_NUM-1:0] hit;
  logic [CH_NUM-1:0] clearMask;
  logic              wdFire;

  assign countNext = countQ + DATA_W'(1);
  assign stepping  = tick & ~strobe.wrCount;
  assign clearMask = strobe.wrStatus ? wrData[CH_NUM-1:0] : '0;
  assign wdFire    = hit[WD_CH] & wdEnQ;

  for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
    assign hit[i] = stepping && (countNext == matchQ[i]);

    always_ff @(posedge clk) begin
      if (rst)                    matchQ[i] <= '0;
      else if (strobe.wrMatch[i]) matchQ[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 countQ <= '0;
    else if (strobe.wrCount) countQ <= wrData;
    else if (tick)           countQ <= countNext;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= (statusQ & ~clearMask) | (hit & ierQ[CH_NUM-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)               ierQ <= '0;
    else if (strobe.wrIer) ierQ <= wrData[IER_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdEnQ    <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= wdFire;
      if (strobe.wrWdog) wdEnQ <= wrData[0];
      else if (wdFire)   wdEnQ <= 1'b0;
    end
  end
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
  import ostmr_pkg::*;
#(
  parameter int IER_BITS = IER_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [CH_NUM-1:0] irq,
  output logic              resetReq
);
  busStrobe_t                    strobe;
  rdSel_t                        rdSel;
  logic [IDX_W-1:0]              rdIdx;
  logic [DATA_W-1:0]             countQ;
  logic [CH_NUM-1:0][DATA_W-1:0] matchQ;
  logic [CH_NUM-1:0]             statusQ;
  logic [IER_BITS-1:0]           ierQ;
  logic                          wdEnQ;

  ostmr_ctrl u_ctrl (
    .wrEn   (busWrEn),
    .addr   (busAddr),
    .strobe (strobe),
    .rdSel  (rdSel),
    .rdIdx  (rdIdx)
  );

  ostmr_dpath #(.IER_BITS(IER_BITS)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .strobe   (strobe),
    .wrData   (busWrData),
    .countQ   (countQ),
    .matchQ   (matchQ),
    .statusQ  (statusQ),
    .ierQ     (ierQ),
    .wdEnQ    (wdEnQ),
    .resetReq (resetReq)
  );

  always_comb begin
    case (rdSel)
      RD_MATCH:  busRdData = matchQ[rdIdx];
      RD_COUNT:  busRdData = countQ;
      RD_STATUS: busRdData = DATA_W'(statusQ);
      RD_WDOG:   busRdData = DATA_W'(wdEnQ);
      RD_IER:    busRdData = DATA_W'(ierQ);
      default:   busRdData = '0;
    endcase
  end

  assign irq = statusQ;
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk
  import ostmr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic [CH_NUM-1:0] irq,
  input logic              resetReq,
  input logic [DATA_W-1:0] countQ,
  input logic              wdEnQ
);
  // R10
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> !resetReq);

  // R9
  wd_armed_chk: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> $past(wdEnQ));

  // R9
  wd_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (resetReq && !($past(busWrEn) && $past(busAddr) == OFS_WDOG)) |-> !wdEnQ);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !($past(busWrEn) && $past(busAddr) == OFS_COUNT)) |-> $stable(countQ));

  // R8
  ier_width_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr == OFS_IER) |-> ((busRdData >> IER_W) == '0));

  for (genvar i = 0; i < CH_NUM; i++) begin : g_irq
    // R4
    irq_tick_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[i]) |-> $past(tick));
  end
endmodule

bind ostmr_top ostmr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .irq       (irq),
  .resetReq  (resetReq),
  .countQ    (countQ),
  .wdEnQ     (wdEnQ)
);

// File: tb/ostmr_top_bench.sv
module ostmr_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  irq;
  logic        resetReq;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  ostmr_top u_ostmr_top (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irq       (irq),
    .resetReq  (resetReq)
  );

  // Behavioural reference state
  logic [31:0] mCnt;
  logic [31:0] mMatch [4];
  logic [11:0] mIer;
  logic [3:0]  mSt;
  logic        mWd;
  logic        mRr;
  logic [31:0] nc;
  logic [3:0]  mHit;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mIer = 0; mSt = 0; mWd = 0; mRr = 0;
      for (int i = 0; i < 4; i++) mMatch[i] = 0;
    end else begin
      nc = mCnt + 1;
      mHit = 0;
      if (tick && !(busWrEn && busAddr == 8'h10))
        for (int i = 0; i < 4; i++) if (nc == mMatch[i]) mHit[i] = 1'b1;
      mRr = mHit[3] && mWd;
      if (busWrEn && busAddr == 8'h14) mSt = mSt & ~busWrData[3:0];
      mSt = mSt | (mHit & mIer[3:0]);
      if (busWrEn && busAddr == 8'h18) mWd = busWrData[0];
      else if (mRr) mWd = 1'b0;
      if (busWrEn && busAddr == 8'h1C) mIer = busWrData[11:0];
      for (int i = 0; i < 4; i++)
        if (busWrEn && busAddr == 8'(i * 4)) mMatch[i] = busWrData;
      if (busWrEn && busAddr == 8'h10) mCnt = busWrData;
      else if (tick) mCnt = nc;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mMatch[0];
      8'h04: return mMatch[1];
      8'h08: return mMatch[2];
      8'h0C: return mMatch[3];
      8'h10: return mCnt;
      8'h14: return {28'd0, mSt};
      8'h18: return {31'd0, mWd};
      8'h1C: return {20'd0, mIer};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return "R12";
      8'h10: return "R2";
      8'h14: return "R7";
      8'h18: return "R9";
      8'h1C: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      check(busRdData == modelRead(busAddr), tagFor(busAddr), busRdData, modelRead(busAddr));
      check(irq == mSt, "R4", {28'd0, irq}, {28'd0, mSt});
      check(resetReq == mRr, "R10", {31'd0, resetReq}, {31'd0, mRr});
    end
  end

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    #1;
    busWrEn = we; busAddr = a; busWrData = d; tick = tk;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h10, 0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1'b0, a, 0, 1'b0);
    #2;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4));
      check(busRdData == 0, "R1", busRdData, 0);
    end
    check(irq == 0 && resetReq == 0, "R1", {27'd0, resetReq, irq}, 0);

    // R12: compare register access
    wr(8'h0C, 32'hDEADBEEF);
    rd(8'h0C);
    check(busRdData == 32'hDEADBEEF, "R12", busRdData, 32'hDEADBEEF);

    // R4: enabled hit
    wr(8'h00, 5); wr(8'h1C, 1); wr(8'h10, 0);
    ticks(5);
    rd(8'h14);
    check(busRdData == 1, "R4", busRdData, 1);
    check(irq[0] == 1'b1, "R4", {31'd0, irq[0]}, 1);
    rd(8'h10);
    check(busRdData == 5, "R2", busRdData, 5);

    // R5: disabled channel
    wr(8'h04, 3); wr(8'h10, 0);
    ticks(3);
    rd(8'h14);
    check(busRdData == 1, "R5", busRdData, 1);
    check(irq[1] == 1'b0, "R5", {31'd0, irq[1]}, 0);

    // R6: load onto a compare value
    wr(8'h1C, 5); wr(8'h08, 7); wr(8'h10, 7);
    rd(8'h14);
    check(busRdData == 1, "R6", busRdData, 1);
    check(irq[2] == 1'b0, "R6", {31'd0, irq[2]}, 0);

    // R7: write-one-to-clear
    wr(8'h14, 2);
    rd(8'h14);
    check(busRdData == 1, "R7", busRdData, 1);
    wr(8'h14, 1);
    rd(8'h14);
    check(busRdData == 0 && irq == 0, "R7", busRdData, 0);
    wr(8'h00, 11); wr(8'h10, 10);
    cyc(1'b1, 8'h14, 1, 1'b1);
    rd(8'h14);
    check(busRdData == 1, "R7", busRdData, 1);

    // R3: write beats tick, then count on
    cyc(1'b1, 8'h10, 100, 1'b1);
    rd(8'h10);
    check(busRdData == 100, "R3", busRdData, 100);
    ticks(3);
    rd(8'h10);
    check(busRdData == 103, "R3", busRdData, 103);

    // R2: hold and wrap
    rd(8'h10); rd(8'h10);
    check(busRdData == 103, "R2", busRdData, 103);
    wr(8'h10, 32'hFFFFFFFE);
    ticks(2);
    rd(8'h10);
    check(busRdData == 0, "R2", busRdData, 0);

    // R9 / R10: watchdog
    wr(8'h14, 32'hF); wr(8'h1C, 1); wr(8'h0C, 2); wr(8'h10, 0); wr(8'h18, 1);
    rd(8'h18);
    check(busRdData == 1, "R9", busRdData, 1);
    ticks(2);
    rd(8'h18);
    check(resetReq == 1'b1, "R9", {31'd0, resetReq}, 1);
    check(busRdData == 0, "R9", busRdData, 0);
    check(irq[3] == 1'b0, "R9", {31'd0, irq[3]}, 0);
    rd(8'h18);
    check(resetReq == 1'b0, "R10", {31'd0, resetReq}, 0);
    wr(8'h10, 0);
    ticks(2);
    rd(8'h18);
    check(resetReq == 1'b0, "R9", {31'd0, resetReq}, 0);

    // R8: enable width
    wr(8'h1C, 32'hFFFFFFFF);
    rd(8'h1C);
    check(busRdData == 32'h00000FFF, "R8", busRdData, 32'h00000FFF);

    // R11: unmapped offsets
    wr(8'h24, 32'h1234); wr(8'h01, 32'h55);
    rd(8'h24);
    check(busRdData == 0, "R11", busRdData, 0);
    rd(8'h01);
    check(busRdData == 0, "R11", busRdData, 0);
    rd(8'h04);
    check(busRdData == 3, "R11", busRdData, 3);
    rd(8'h00);
    check(busRdData == 11, "R11", busRdData, 11);

    rd(8'h10);
    rd(8'h10);
    finishRun();
  end
endmodule